// File: doc/BRIEF.md
# Time-over-threshold hit recorder

Per-channel digital front end for a group of silicon strip channels. Each channel delivers two comparator bits that are already synchronised to the system clock: a low threshold used to time the pulse and a higher threshold that marks a real hit. A `tick` strobe, one per slow sampling period, samples both comparators and advances a shared event-time count. The block stamps the moment the low comparator rises and the moment it falls. The gap between the two stamps is the pulse-height measure, and it grows roughly logarithmically for large charges.

Zero suppression drops pulses that no high-threshold hit ever confirms. A pulse counts as confirmed when the high comparator fires on the channel itself or on either adjacent channel. The strips next to a real hit therefore keep their low-threshold timing, and a charge centroid can still be formed downstream. Recording happens only while the `spill` level is high. A pulse still open when the spill ends is closed with a forced, flagged record. Each channel has its own small first-in first-out store, read through a valid/pop pair.

Top module: `tot_hit_recorder`

## Requirements
- R1: Every cycle with `tick` high takes one comparator sample. On such a cycle the event time is 0 if `spill` is high and was low on the previous tick, and otherwise one more than on the previous tick, wrapping modulo 2^TW. Every record carries the event time of the tick that produced it.
- R2: If a tick finds `spill` high and the low comparator rising (high now, low at the previous tick), and the channel is qualified on that same tick, a leading record stamped with that tick's time is written.
- R3: A channel is qualified on a tick when the high comparator is set on that channel or on channel index ±1. Channel 0 and channel NCH-1 each have only one neighbour, and the index does not wrap around.
- R4: A rise that is not qualified is held as pending. If a later tick qualifies the channel while the low comparator is still high, a leading record is written stamped with the time of the original rise. If the low comparator falls first, no record is written.
- R5: After a leading record, the first tick that finds the low comparator low writes a trailing record stamped with that tick's time. A channel never writes a trailing record without a preceding leading record.
- R6: A tick that finds `spill` low closes an open pulse with a trailing record stamped with that tick's time and with the saturation bit set, and discards a pending pulse. A rise seen while `spill` is low is ignored.
- R7: Record layout: bits [TW-1:0] hold the event time, bit TW is the saturation flag, bit TW+1 is the edge type (1 for leading, 0 for trailing), and the top CW bits hold the channel index.
- R8: Each channel stores up to DEPTH records in arrival order. `rec_valid` shows that the head record is present on its slice of `rec_data`. A cycle with `pop` high and `rec_valid` high removes the head, and the head does not change while it is not popped.
- R9: A record that arrives while the channel store is full is dropped, and that channel's `ovf` is set. A pop in the same cycle does not make room for it. `ovf` stays set until a tick that starts a new spill.
- R10: After reset every store is empty, every `ovf` is clear and no pulse is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per sampling period |
| spill | input | 1 | High while acquisition is allowed |
| lo_cmp | input | NCH | Low-threshold comparator bit per channel |
| hi_cmp | input | NCH | High-threshold comparator bit per channel |
| pop | input | NCH | Remove the head record of each channel |
| rec_valid | output | NCH | A head record is present on the channel |
| rec_data | output | NCH*RW | Head record per channel, channel c at [c*RW +: RW] |
| ovf | output | NCH | Sticky record-dropped flag per channel |

## Verification
The bench drives rises that are qualified only through a neighbour and a rise on channel 0 whose only high hit is on the last channel. A design that wrapped the neighbour index, or ignored neighbours, would either record that pulse or lose the neighbour pulses. A rise is left pending for one tick and then qualified, so a design that stamped the qualifying tick would return the wrong leading time. A pending pulse that falls unconfirmed must vanish. A pulse still high when the spill ends must close with the saturation bit, and an edge outside the spill must leave no trace. The store is filled past its depth to check that only the overflowing records are dropped, that `ovf` survives draining and clears only at the next spill start. A run of more than 2^TW ticks checks that the time count wraps.

// File: rtl/tot_pkg.sv
package tot_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_PEND = 2'd1,
    CH_OPEN = 2'd2
  } ch_state_e;

  localparam logic EDGE_LEAD  = 1'b1;
  localparam logic EDGE_TRAIL = 1'b0;

endpackage

// File: rtl/tot_timebase.sv
module tot_timebase #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          spill,
  output logic [TW-1:0] t_now,
  output logic [TW-1:0] tcnt,
  output logic          spill_rise
);

  logic spill_q;

  // spill level seen on this tick but not on the previous one
  assign spill_rise = spill & ~spill_q;
  assign t_now      = spill_rise ? '0 : tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt    <= '0;
      spill_q <= 1'b0;
    end else if (tick) begin
      tcnt    <= t_now + 1'b1;
      spill_q <= spill;
    end
  end

endmodule

// File: rtl/tot_chan.sv
module tot_chan
  import tot_pkg::*;
#(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          spill,
  input  logic          lo,
  input  logic          qual,
  input  logic [TW-1:0] t_now,
  output logic          wr,
  output logic          wr_lead,
  output logic          wr_sat,
  output logic [TW-1:0] wr_time
);

  ch_state_e     st, st_d;
  logic          lo_q;
  logic [TW-1:0] held;
  logic          lo_rise;
  logic          want;

  assign lo_rise = lo & ~lo_q;

  always_comb begin
    st_d    = st;
    want    = 1'b0;
    wr_lead = EDGE_TRAIL;
    wr_sat  = 1'b0;
    wr_time = t_now;
    unique case (st)
      CH_IDLE: begin
        if (spill && lo_rise) begin
          if (qual) begin
            want    = 1'b1;
            wr_lead = EDGE_LEAD;
            st_d    = CH_OPEN;
          end else begin
            st_d = CH_PEND;
          end
        end
      end
      CH_PEND: begin
        if (!spill || !lo) begin
          st_d = CH_IDLE;
        end else if (qual) begin
          want    = 1'b1;
          wr_lead = EDGE_LEAD;
          wr_time = held;
          st_d    = CH_OPEN;
        end
      end
      CH_OPEN: begin
        if (!spill) begin
          want   = 1'b1;
          wr_sat = 1'b1;
          st_d   = CH_IDLE;
        end else if (!lo) begin
          want = 1'b1;
          st_d = CH_IDLE;
        end
      end
      default: st_d = CH_IDLE;
    endcase
  end

  assign wr = want & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= CH_IDLE;
      lo_q <= 1'b0;
      held <= '0;
    end else if (tick) begin
      st   <= st_d;
      lo_q <= lo;
      if (st == CH_IDLE && st_d == CH_PEND) held <= t_now;
    end
  end

endmodule

// File: rtl/tot_fifo.sv
module tot_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == (AW + 1)'(DEPTH));
  assign valid   = (cnt != '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_next(wp);
      if (pop_ok)  rp <= ptr_next(rp);
      cnt <= cnt + (push_ok ? 1'b1 : 1'b0) - (pop_ok ? 1'b1 : 1'b0);
    end
  end

endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder #(
  parameter  int NCH   = 8,
  parameter  int TW    = 10,
  parameter  int DEPTH = 4,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RW    = CW + TW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            spill,
  input  logic [NCH-1:0]  lo_cmp,
  input  logic [NCH-1:0]  hi_cmp,
  input  logic [NCH-1:0]  pop,
  output logic [NCH-1:0]  rec_valid,
  output logic [NCH*RW-1:0] rec_data,
  output logic [NCH-1:0]  ovf
);

  function automatic logic [RW-1:0] rec_pack(input logic [CW-1:0] ch, input logic lead,
                                             input logic sat, input logic [TW-1:0] t);
    return {ch, lead, sat, t};
  endfunction

  logic [TW-1:0]  t_now, tcnt;
  logic           spill_rise;
  logic [NCH-1:0] qual, wr_en, wr_lead, wr_sat, fifo_full, drop;
  logic [TW-1:0]  wr_time [NCH];

  tot_timebase #(.TW(TW)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spill(spill),
    .t_now(t_now), .tcnt(tcnt), .spill_rise(spill_rise)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (NCH == 1) begin : g_q1
      assign qual[c] = hi_cmp[c];
    end else if (c == 0) begin : g_qlo
      assign qual[c] = hi_cmp[c] | hi_cmp[c+1];
    end else if (c == NCH - 1) begin : g_qhi
      assign qual[c] = hi_cmp[c] | hi_cmp[c-1];
    end else begin : g_qmid
      assign qual[c] = hi_cmp[c-1] | hi_cmp[c] | hi_cmp[c+1];
    end

    tot_chan #(.TW(TW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .spill(spill),
      .lo(lo_cmp[c]), .qual(qual[c]), .t_now(t_now),
      .wr(wr_en[c]), .wr_lead(wr_lead[c]), .wr_sat(wr_sat[c]), .wr_time(wr_time[c])
    );

    tot_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(wr_en[c]),
      .din(rec_pack(CW'(c), wr_lead[c], wr_sat[c], wr_time[c])),
      .pop(pop[c]),
      .valid(rec_valid[c]),
      .dout(rec_data[c*RW +: RW]),
      .full(fifo_full[c])
    );

    assign drop[c] = wr_en[c] & fifo_full[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovf[c] <= 1'b0;
      end else begin
        if (tick && spill_rise) ovf[c] <= 1'b0;
        if (drop[c])            ovf[c] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tot_hit_recorder_chk.sv
module tot_hit_recorder_chk #(
  parameter int NCH = 8,
  parameter int TW  = 10,
  parameter int RW  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              spill,
  input logic              spill_rise,
  input logic [TW-1:0]     tcnt,
  input logic [NCH-1:0]    wr_en,
  input logic [NCH-1:0]    wr_lead,
  input logic [NCH-1:0]    wr_sat,
  input logic [NCH-1:0]    fifo_full,
  input logic [NCH-1:0]    pop,
  input logic [NCH-1:0]    rec_valid,
  input logic [NCH*RW-1:0] rec_data,
  input logic [NCH-1:0]    ovf
);

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !spill_rise) |=> tcnt == TW'($past(tcnt) + 1'b1)); // R1
  AST_TIME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && spill_rise) |=> tcnt == TW'(1)); // R1

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_WRITE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[c] |-> tick); // R2
    AST_LEAD_IN_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && wr_lead[c]) |-> spill); // R6
    AST_SAT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[c] && wr_sat[c]) |-> (!spill && !wr_lead[c])); // R6
    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid[c] && !pop[c]) |=> (rec_valid[c] && $stable(rec_data[c*RW +: RW]))); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[c]) |-> $past(wr_en[c] && fifo_full[c])); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf[c]) && !$past(tick && spill_rise)) |-> ovf[c]); // R9
  end

endmodule

bind tot_hit_recorder tot_hit_recorder_chk #(.NCH(NCH), .TW(TW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .spill(spill), .spill_rise(spill_rise),
  .tcnt(tcnt), .wr_en(wr_en), .wr_lead(wr_lead), .wr_sat(wr_sat),
  .fifo_full(fifo_full), .pop(pop), .rec_valid(rec_valid), .rec_data(rec_data),
  .ovf(ovf)
);

// File: tb/tot_hit_recorder_bench.sv
module tot_hit_recorder_bench;

  localparam int NCH = 8;
  localparam int TW = 10;
  localparam int DEPTH = 4;
  localparam int CW = 3;
  localparam int RW = CW + TW + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic tick = 1'b0, spill = 1'b0;
  logic [NCH-1:0] lo_cmp = '0, hi_cmp = '0, pop = '0;
  logic [NCH-1:0] rec_valid, ovf;
  logic [NCH*RW-1:0] rec_data;

  tot_hit_recorder #(.NCH(NCH), .TW(TW), .DEPTH(DEPTH)) u_tot_hit_recorder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .spill(spill),
    .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .pop(pop),
    .rec_valid(rec_valid), .rec_data(rec_data), .ovf(ovf)
  );

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // record per R7: {channel, edge(1=leading), sat, time}
  function automatic logic [RW-1:0] mk(input int c, input bit lead, input bit sat, input int t);
    return {CW'(c), lead, sat, TW'(t)};
  endfunction

  // ---------------- behavioural reference model ----------------
  int   m_st [NCH];      // 0 idle, 1 waiting for confirmation, 2 open
  int   m_held [NCH];
  bit   m_lo [NCH];
  bit   m_ovf [NCH];
  int   m_t;
  bit   m_sq;
  logic [RW-1:0] mq [NCH][$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = 0; m_sq = 0;
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0; m_held[c] = 0; m_lo[c] = 0; m_ovf[c] = 0;
        mq[c].delete();
      end
    end else begin
      bit was_full [NCH];
      bit start;
      int tn;
      for (int c = 0; c < NCH; c++) begin
        was_full[c] = (mq[c].size() == DEPTH);
        if (pop[c] && mq[c].size() > 0) void'(mq[c].pop_front());
      end
      if (tick) begin
        start = spill && !m_sq;
        tn = start ? 0 : m_t;
        for (int c = 0; c < NCH; c++) begin
          bit have, ok;
          logic [RW-1:0] r;
          have = 0; r = '0;
          ok = hi_cmp[c] || (c > 0 && hi_cmp[(c > 0) ? c-1 : 0]) ||
               (c < NCH-1 && hi_cmp[(c < NCH-1) ? c+1 : c]);
          if (start) m_ovf[c] = 0;
          if (!spill) begin
            if (m_st[c] == 2) begin have = 1; r = mk(c, 0, 1, tn); end
            m_st[c] = 0;
          end else if (m_st[c] == 0) begin
            if (lo_cmp[c] && !m_lo[c]) begin
              if (ok) begin have = 1; r = mk(c, 1, 0, tn); m_st[c] = 2; end
              else begin m_held[c] = tn; m_st[c] = 1; end
            end
          end else if (m_st[c] == 1) begin
            if (!lo_cmp[c]) m_st[c] = 0;
            else if (ok) begin have = 1; r = mk(c, 1, 0, m_held[c]); m_st[c] = 2; end
          end else begin
            if (!lo_cmp[c]) begin have = 1; r = mk(c, 0, 0, tn); m_st[c] = 0; end
          end
          if (have) begin
            if (was_full[c]) m_ovf[c] = 1;
            else mq[c].push_back(r);
          end
          m_lo[c] = lo_cmp[c];
        end
        m_t = (tn + 1) % (1 << TW);
        m_sq = spill;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit ok;
      ok = 1;
      for (int c = 0; c < NCH; c++) begin
        if (rec_valid[c] !== (mq[c].size() != 0)) begin
          ok = 0;
          $display("FAIL R8 model ch%0d valid act=%0b exp=%0b", c, rec_valid[c], mq[c].size() != 0);
        end else if (rec_valid[c] && rec_data[c*RW +: RW] !== mq[c][0]) begin
          ok = 0;
          $display("FAIL R7 model ch%0d head act=%h exp=%h", c, rec_data[c*RW +: RW], mq[c][0]);
        end
        if (ovf[c] !== m_ovf[c]) begin
          ok = 0;
          $display("FAIL R9 model ch%0d ovf act=%0b exp=%0b", c, ovf[c], m_ovf[c]);
        end
      end
      n_chk++;
      if (!ok) n_err++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi, input bit sp);
    @(negedge clk);
    lo_cmp = lo; hi_cmp = hi; spill = sp; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic take(input int c, input bit ev, input logic [RW-1:0] er, input string tag);
    @(negedge clk);
    chk(rec_valid[c] == ev && (!ev || rec_data[c*RW +: RW] == er), tag,
        {rec_valid[c], rec_data[c*RW +: RW]}, {ev, er});
    if (rec_valid[c]) begin
      pop[c] = 1'b1;
      @(negedge clk);
      pop[c] = 1'b0;
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(rec_valid == '0 && ovf == '0, "R10 reset state", {rec_valid, ovf}, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (2) @(negedge clk);

    // ---- scenario 1: qualification, pending, spill end ----
    step(8'h00, 8'h00, 1);          // t0 spill start
    step(8'h04, 8'h00, 1);          // t1 ch2 rises unconfirmed
    step(8'h2F, 8'h84, 1);          // t2 ch1/ch3 via neighbour, ch2 late confirm, ch0 hi7 only, ch5 none
    step(8'h2F, 8'h00, 1);          // t3
    step(8'h04, 8'h00, 1);          // t4 ch1/ch3 fall, ch0/ch5 fall unconfirmed
    step(8'h04, 8'h00, 1);          // t5
    step(8'h04, 8'h00, 0);          // t6 spill ends with ch2 open
    step(8'h10, 8'h10, 0);          // t7 ch4 edge outside spill
    step(8'h00, 8'h00, 0);
    chk(ovf == '0, "R9 no overflow scenario1", ovf, 0);
    take(2, 1, mk(2, 1, 0, 1), "R4 pending lead keeps rise time");
    take(2, 1, mk(2, 0, 1, 6), "R6 forced saturated trailing");
    take(2, 0, '0, "R5 ch2 empty after pair");
    take(1, 1, mk(1, 1, 0, 2), "R3 lead via neighbour ch1");
    take(1, 1, mk(1, 0, 0, 4), "R5 trailing ch1");
    take(3, 1, mk(3, 1, 0, 2), "R2 lead ch3");
    take(3, 1, mk(3, 0, 0, 4), "R5 trailing ch3");
    take(0, 0, '0, "R3 no wrap from last channel");
    take(5, 0, '0, "R4 unconfirmed pulse dropped");
    take(4, 0, '0, "R6 edge outside spill ignored");

    // ---- scenario 2: overflow ----
    step(8'h00, 8'h00, 1);          // t0
    for (int p = 0; p < 3; p++) begin
      step(8'h01, 8'h01, 1);
      step(8'h00, 8'h00, 1);
    end
    chk(ovf[0] == 1'b1, "R9 ovf set when full", ovf[0], 1);
    chk(ovf[7:1] == '0, "R9 other channels clean", ovf, 1);
    step(8'h00, 8'h00, 0);
    take(0, 1, mk(0, 1, 0, 1), "R8 order first");
    take(0, 1, mk(0, 0, 0, 2), "R8 order second");
    take(0, 1, mk(0, 1, 0, 3), "R8 order third");
    take(0, 1, mk(0, 0, 0, 4), "R9 last stored before drop");
    take(0, 0, '0, "R9 dropped records absent");
    chk(ovf[0] == 1'b1, "R9 ovf sticky after drain", ovf[0], 1);
    step(8'h00, 8'h00, 1);
    chk(ovf[0] == 1'b0, "R9 ovf cleared at spill start", ovf[0], 0);
    step(8'h00, 8'h00, 0);

    // ---- scenario 3: time wrap ----
    step(8'h00, 8'h00, 1);          // t0
    for (int k = 1; k <= 1024; k++) step(8'h00, 8'h00, 1);
    step(8'h10, 8'h10, 1);          // tick 1025 -> time 1
    step(8'h00, 8'h00, 1);          // time 2
    step(8'h00, 8'h00, 0);
    take(4, 1, mk(4, 1, 0, 1), "R1 time wraps lead");
    take(4, 1, mk(4, 0, 0, 2), "R1 time wraps trailing");

    // ---- random traffic against the model ----
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 150) == 0) spill = ~spill;
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 5) == 0) lo_cmp[c] = ~lo_cmp[c];
        hi_cmp[c] = lo_cmp[c] & ($urandom_range(0, 3) == 0);
        pop[c] = ($urandom_range(0, 4) == 0);
      end
    end
    @(negedge clk);
    pop = '0; tick = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule